// File: doc/BRIEF.md
# Gated Multi-Ratio Clock Divider

This block derives three slower clocks from one input clock: one at half, one at a quarter and one at an eighth of the input rate. Every output is a bit of a single synchronous binary counter, and all bits are clocked by the same internal clock. Any edge that two outputs share therefore falls on the same input edge. The number of stages is a parameter, so the block can be built with more or fewer outputs.

A common enable input starts and stops the divider. The enable is registered on the falling edge of the input clock. Its registered copy is ANDed with the input clock to form the gated clock that drives the counter. The gate can only open or close while the input clock is low, so the gated clock never carries a shortened high phase. While the gate is closed the counter keeps its phase, and counting resumes from that phase when the gate opens again.

An asynchronous active-high reset clears the counter and the registered enable. If several instances share the same reset, they come out of it in step with each other.

Top module: `ratio_clk_div`

## Requirements
- R1: While `rst` is high, `div_q` is all zeros and the registered enable is closed. Raising `rst` clears the outputs at once, without waiting for a clock edge.
- R2: `div_q[0]` (the divide-by-2 output) toggles on every rising edge of `clk_in` at which the gate is open. With the enable held high, its period is 2 input cycles.
- R3: `div_q[1]` (the divide-by-4 output) toggles on an open rising edge only when `div_q[0]` is high just before that edge. With the enable held high, its period is 4 input cycles.
- R4: `div_q[2]` (the divide-by-8 output) toggles on an open rising edge only when both `div_q[0]` and `div_q[1]` are high just before that edge. With the enable held high, its period is 8 input cycles.
- R5: A slower output never changes on an edge where the next faster output does not also change. When the count wraps from all ones, every output falls on the same edge; this happens on every 8th open edge after reset.
- R6: `en` is captured on the falling edge of `clk_in`. A change of `en` affects only the first rising edge of `clk_in` that follows that falling edge.
- R7: The registered enable changes only while `clk_in` is low. As a result, no high pulse on `div_q[i]` is ever shorter than 2^i input cycles, whatever the timing of `en`.
- R8: While the gate is closed, `div_q` holds its value. When the gate reopens, counting continues from the held value with no restart.
- R9: After `rst` falls, the first count happens at the first rising edge that follows a falling edge at which `en` was high. If `en` stays low after reset, the outputs stay at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst | input | 1 | Asynchronous active-high reset; aligns the divider phase |
| en | input | 1 | Enable; sampled on the falling edge of `clk_in` |
| div_q | output | STAGES | Divided clocks; bit i runs at 1/2^(i+1) of the input rate |

## Verification
The bench builds the block with the default of three stages. This makes the full count short enough that a 40-cycle run with the enable held high sweeps every wrap point several times. In that run the bench checks the rise-to-rise spacing of each output and checks that all outputs fall together. Over several hundred cycles the enable is then toggled at random. A scoreboard compares every output sample against a model that follows the falling-edge capture rule, and tracks the width of each high pulse. Resets asserted mid-run and releases with the enable low or high exercise the asynchronous clear and the first-count timing.

// File: rtl/rcd_pkg.sv
`timescale 1ns/1ps
package rcd_pkg;

    // Default number of divide stages (ratios 2, 4, 8).
    localparam int unsigned RCD_STAGES = 3;

    // State of the registered clock gate.
    typedef enum logic {
        GATE_CLOSED = 1'b0,
        GATE_OPEN   = 1'b1
    } gate_state_e;

    // Division ratio of stage number idx (0-based).
    function automatic int unsigned rcd_ratio(input int unsigned idx);
        return 32'd2 << idx;
    endfunction

endpackage

// File: rtl/rcd_gate.sv
`timescale 1ns/1ps
module rcd_gate
    import rcd_pkg::*;
(
    input  logic        clk_in,
    input  logic        rst,
    input  logic        en,
    output logic        gclk,
    output gate_state_e gate_q
);

    // The enable is captured while the clock falls, so the gate only moves
    // during the low phase of clk_in.
    always_ff @(negedge clk_in or posedge rst) begin
        if (rst) begin
            gate_q <= GATE_CLOSED;
        end else begin
            gate_q <= en ? GATE_OPEN : GATE_CLOSED;
        end
    end

    assign gclk = clk_in & (gate_q == GATE_OPEN);

    // R7
    always @(gate_q) begin
        if (!rst) begin
            gate_low_chk: assert (clk_in == 1'b0)
                else $error("gate moved while clock high");
        end
    end

endmodule

// File: rtl/rcd_stage.sv
`timescale 1ns/1ps
module rcd_stage (
    input  logic clk,
    input  logic rst,
    input  logic tog,
    output logic q
);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            q <= 1'b0;
        end else if (tog) begin
            q <= ~q;
        end
    end

endmodule

// File: rtl/rcd_chain.sv
`timescale 1ns/1ps
module rcd_chain #(
    parameter int unsigned STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    output logic [STAGES-1:0] q
);

    // run_hi[i] is high when every stage below i is high.
    logic [STAGES:0] run_hi;

    assign run_hi[0] = 1'b1;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        assign run_hi[i+1] = run_hi[i] & q[i];

        rcd_stage u_stg (
            .clk (clk),
            .rst (rst),
            .tog (run_hi[i]),
            .q   (q[i])
        );
    end

endmodule

// File: rtl/ratio_clk_div.sv
`timescale 1ns/1ps
module ratio_clk_div
    import rcd_pkg::*;
#(
    parameter int unsigned STAGES = RCD_STAGES
) (
    input  logic              clk_in,
    input  logic              rst,
    input  logic              en,
    output logic [STAGES-1:0] div_q
);

    gate_state_e gate_q;
    logic        gclk;

    rcd_gate u_gate (
        .clk_in (clk_in),
        .rst    (rst),
        .en     (en),
        .gclk   (gclk),
        .gate_q (gate_q)
    );

    rcd_chain #(.STAGES(STAGES)) u_chain (
        .clk (gclk),
        .rst (rst),
        .q   (div_q)
    );

    // R1
    reset_clear_chk: assert property (@(negedge clk_in)
        rst |-> ((div_q == '0) && (gate_q == GATE_CLOSED)));

    // R8
    closed_hold_chk: assert property (@(posedge clk_in) disable iff (rst)
        (gate_q == GATE_CLOSED) |=> $stable(div_q));

    for (genvar i = 0; i < STAGES; i++) begin : g_chk
        if (i == 0) begin : g_first
            // R2
            half_toggle_chk: assert property (@(posedge clk_in) disable iff (rst)
                (gate_q == GATE_OPEN) |=> (div_q[0] != $past(div_q[0])));
        end else begin : g_upper
            // R3 R4
            carry_toggle_chk: assert property (@(posedge clk_in) disable iff (rst)
                ((gate_q == GATE_OPEN) && (&div_q[i-1:0])) |=> (div_q[i] != $past(div_q[i])));
            // R3 R4
            carry_hold_chk: assert property (@(posedge clk_in) disable iff (rst)
                !(&div_q[i-1:0]) |=> $stable(div_q[i]));
            // R5
            edge_align_chk: assert property (@(posedge clk_in) disable iff (rst)
                (div_q[i] != $past(div_q[i])) |-> (div_q[i-1] != $past(div_q[i-1])));
        end
    end

endmodule

// File: tb/sim_ratio_clk_div.sv
`timescale 1ns/1ps
module sim_ratio_clk_div;

    localparam int unsigned STAGES = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b0;
    logic              en  = 1'b0;
    logic [STAGES-1:0] div_q;

    ratio_clk_div #(.STAGES(STAGES)) u0 (
        .clk_in (clk),
        .rst    (rst),
        .en     (en),
        .div_q  (div_q)
    );

    // 200 MHz
    initial forever #2.5 clk = ~clk;

    typedef struct {
        logic [STAGES-1:0] val;
        string             tag;
    } exp_t;

    exp_t              sb_q[$];
    int                errors = 0;
    int                checks = 0;
    bit                done = 1'b0;
    logic [STAGES-1:0] m_cnt = '0;
    bit                m_rst = 1'b0;
    bit                m_enq = 1'b0;
    bit                cont_en = 1'b0;
    string             cur_tag = "R1";

    int                cyc = 0;
    int                hi_len[STAGES] = '{default: 0};
    int                last_rise[STAGES] = '{default: -1};
    logic [STAGES-1:0] prev_q = '0;

    function automatic string bit_tag(input int idx);
        case (idx)
            0:       return "R2";
            1:       return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: called at posedge+1. Models the last edge, applies new inputs,
    // pushes the value the outputs should show now.
    task automatic step(input bit rst_v, input bit en_v);
        exp_t e;
        if (m_rst)      m_cnt = '0;
        else if (m_enq) m_cnt = m_cnt + 1'b1;
        rst = rst_v;
        en  = en_v;
        if (rst_v) begin
            m_rst = 1'b1;
            m_enq = 1'b0;
            m_cnt = '0;
        end else begin
            m_rst = 1'b0;
            m_enq = en_v;   // captured at the coming falling edge (R6)
        end
        e.val = m_cnt;
        e.tag = cur_tag;
        sb_q.push_back(e);
        @(posedge clk);
        #1;
    endtask

    // Monitor: samples at posedge+2, before the falling edge.
    always @(posedge clk) begin
        #2;
        cyc++;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            for (int i = 0; i < STAGES; i++) begin
                check(div_q[i] === e.val[i],
                      $sformatf("%s/%s bit %0d", e.tag, bit_tag(i), i),
                      int'(div_q[i]), int'(e.val[i]));
            end
        end
        if (rst) begin
            for (int i = 0; i < STAGES; i++) hi_len[i] = 0;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                if (div_q[i] === 1'b1) begin
                    hi_len[i]++;
                end else begin
                    // R7: no shortened high pulse
                    if (hi_len[i] != 0)
                        check(hi_len[i] >= (1 << i), "R7 pulse width", hi_len[i], 1 << i);
                    hi_len[i] = 0;
                end
            end
            // R5: wrap from all ones drops every output together
            if ((&prev_q) && (div_q !== prev_q))
                check(div_q == '0, "R5 common fall", int'(div_q), 0);
        end
        for (int i = 0; i < STAGES; i++) begin
            if (!cont_en) begin
                last_rise[i] = -1;
            end else if (div_q[i] && !prev_q[i]) begin
                if (last_rise[i] >= 0)
                    check((cyc - last_rise[i]) == (2 << i),
                          $sformatf("%s period", bit_tag(i)),
                          cyc - last_rise[i], 2 << i);
                last_rise[i] = cyc;
            end
        end
        prev_q = div_q;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        #1;
        rst   = 1'b1;
        m_rst = 1'b1;
        en    = 1'b1;
        @(posedge clk);
        #1;
        // R1: reset state, enable high is ignored
        cur_tag = "R1";
        repeat (3) step(1'b1, 1'b1);
        // R9: release with enable high
        cur_tag = "R9";
        repeat (3) step(1'b0, 1'b1);
        // R2 R3 R4 R5: steady enable
        cur_tag = "R2/R3/R4";
        cont_en = 1'b1;
        repeat (40) step(1'b0, 1'b1);
        cont_en = 1'b0;
        // R8: hold while closed, resume from held phase
        cur_tag = "R8";
        repeat (6) step(1'b0, 1'b0);
        repeat (5) step(1'b0, 1'b1);
        repeat (4) step(1'b0, 1'b0);
        // R6 R7: random enable
        cur_tag = "R6";
        for (int k = 0; k < 300; k++) step(1'b0, ($urandom % 3) != 0);
        // R1: asynchronous clear mid-run
        cur_tag = "R1";
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        // R9: release with enable low, then raise it
        cur_tag = "R9";
        repeat (3) step(1'b0, 1'b0);
        repeat (20) step(1'b0, 1'b1);
        #5;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule